// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog

This block is a watchdog timer reached through a small byte-addressed register port. A prescaler divides the core clock into ticks. On each tick, a 10-bit down-counter loses one count while the halt control is clear. Software keeps the system alive by writing to the reload location. That write returns the counter to a programmable initial value.

If the counter runs out, the block does not act on the first expiry. It raises a first-timeout flag and reloads itself. Only a second expiry, with that flag still uncleared, raises the second-timeout flag and produces a reset request. An external input can hold the reset request off, but the flags are recorded in every case. All status flags are write-one-to-clear. Clearing the first-timeout flag while servicing the timer means two full countdowns are needed again before a reset.

The register port has no handshake. A write takes effect at the clock edge on which the strobe is sampled. Read data is a combinational view of the register at the given address.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the halt bit is 1, every status flag is 0, the initial value is 4, the counter reads 4 and the reset request is low.
- R2: While running, a tick occurs once every TICK_DIV clocks. Each tick lowers a non-zero counter by one. A tick that finds the counter at 0 is an expiry, so a countdown from value N lasts (N+1)*TICK_DIV clocks.
- R3: Offset 0x12 holds the 10-bit initial value, taken from write data bits 9:0. A write with a value of 0 to 3 is ignored, and a read returns the stored value.
- R4: Any write to offset 0x00 loads the counter with the initial value and restarts the prescaler, so a tick due on that clock is dropped. This works whether the timer is halted or running. A read of offset 0x00 returns the counter.
- R5: Bit 11 of offset 0x08 is the halt control. While it is 1 the counter holds its value. The bit reads back as written.
- R6: On an expiry with the first-timeout flag clear, that flag (bit 3 of offset 0x04) is set and the counter reloads from the initial value.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a set fall on the same clock, the set wins.
- R8: An expiry that finds the first-timeout flag clear does not raise the reset request.
- R9: An expiry that finds the first-timeout flag set sets the second-timeout flag (bit 1 of offset 0x06) and raises the reset request.
- R10: The reset request is high for exactly one clock per qualifying expiry. The second-timeout flag stays set until software clears it.
- R11: An expiry that finds the second-timeout flag already set also sets the boot-status flag (bit 2 of offset 0x06).
- R12: While the no-reboot input is high, the reset request stays low. The status flags are still set as R6, R9 and R11 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | DATA_W | Read data for the register at reg_addr |
| reboot_block_i | input | 1 | When high, suppresses the reset request |
| reset_req_o | output | 1 | One-clock reset request pulse |

## Verification
The bench runs countdowns to their exact expiry clock. A design that is off by one tick, or that double-decrements when a reload meets a tick, shows the wrong count or flags at the predicted cycle. It probes the escalation chain from first expiry to second timeout to boot flag. Along that chain, a design that resets on the first expiry, or that loses the latched second-timeout flag, gives the wrong reset-pulse count or flag word. The bench also writes initial values below 4 and writes zeros to set flags, so a design that accepts the values or clears the flags is exposed. It holds the no-reboot input during a double expiry and expects flags to be set with no pulse. It also checks that the counter stays frozen under halt.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFS_RELOAD = 'h00;
  localparam int OFS_STS1   = 'h04;
  localparam int OFS_STS2   = 'h06;
  localparam int OFS_CTL1   = 'h08;
  localparam int OFS_INIT   = 'h12;

  localparam int BIT_FIRST_TO  = 3;
  localparam int BIT_SECOND_TO = 1;
  localparam int BIT_BOOT      = 2;
  localparam int BIT_HALT      = 11;

  localparam int INIT_MIN = 4;

  typedef struct packed {
    logic first;
    logic second;
    logic boot;
  } wdt_flags_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_DIV = 75_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run || restart || tick_o) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W   = 10,
  parameter int RST_VAL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick && !reload && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (reload || expire_o) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       block,
  input  wdt_flags_t clr,
  output wdt_flags_t flags_o,
  output logic       req_o
);
  wdt_flags_t flags_q;
  wdt_flags_t set;

  always_comb begin
    set.first  = expire && !flags_q.first;
    set.second = expire && flags_q.first;
    set.boot   = expire && flags_q.first && flags_q.second;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      req_o   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr) | set;
      req_o   <= set.second && !block;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  wdt_flags_t        flags,
  output logic [CNT_W-1:0]  init_o,
  output logic              halt_o,
  output logic              reload_o,
  output wdt_flags_t        clr_o,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(INIT_MIN);

  logic [CNT_W-1:0] init_q;
  logic             halt_q;
  logic             hit_rld, hit_s1, hit_s2, hit_ctl, hit_init;

  assign hit_rld  = (addr == ADDR_W'(OFS_RELOAD));
  assign hit_s1   = (addr == ADDR_W'(OFS_STS1));
  assign hit_s2   = (addr == ADDR_W'(OFS_STS2));
  assign hit_ctl  = (addr == ADDR_W'(OFS_CTL1));
  assign hit_init = (addr == ADDR_W'(OFS_INIT));

  assign reload_o     = we && hit_rld;
  assign clr_o.first  = we && hit_s1 && wdata[BIT_FIRST_TO];
  assign clr_o.second = we && hit_s2 && wdata[BIT_SECOND_TO];
  assign clr_o.boot   = we && hit_s2 && wdata[BIT_BOOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= CNT_W'(INIT_RST);
      halt_q <= 1'b1;
    end else if (we) begin
      if (hit_init && (wdata[CNT_W-1:0] >= FLOOR)) init_q <= wdata[CNT_W-1:0];
      if (hit_ctl) halt_q <= wdata[BIT_HALT];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_rld)  rdata[CNT_W-1:0] = cnt;
    if (hit_s1)   rdata[BIT_FIRST_TO] = flags.first;
    if (hit_s2) begin
      rdata[BIT_SECOND_TO] = flags.second;
      rdata[BIT_BOOT]      = flags.boot;
    end
    if (hit_ctl)  rdata[BIT_HALT] = halt_q;
    if (hit_init) rdata[CNT_W-1:0] = init_q;
  end

  assign init_o = init_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 75_000_000,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              reboot_block_i,
  output logic              reset_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] init_q;
  logic             halt_q;
  logic             reload_wr;
  logic             tick;
  logic             expire;
  wdt_flags_t       flags;
  wdt_flags_t       clr;

  wdt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .INIT_RST(INIT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt(cnt_q), .flags(flags), .init_o(init_q), .halt_o(halt_q),
    .reload_o(reload_wr), .clr_o(clr), .rdata(reg_rdata)
  );

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!halt_q), .restart(reload_wr), .tick_o(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .RST_VAL(INIT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_wr),
    .load_val(init_q), .cnt_o(cnt_q), .expire_o(expire)
  );

  wdt_status u_sts (
    .clk(clk), .rst_n(rst_n), .expire(expire), .block(reboot_block_i),
    .clr(clr), .flags_o(flags), .req_o(reset_req_o)
  );
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reboot_block_i,
  input logic              reset_req_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  init_q,
  input logic              halt_q,
  input logic              tick,
  input logic              second_flag
);
  logic rld;
  assign rld = reg_we && (reg_addr == '0);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> !reset_req_o); // R10
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req_o) |-> !$past(reboot_block_i)); // R12
  AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> second_flag); // R9
  AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= CNT_W'(4)); // R3
  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rld |=> cnt_q == $past(init_q)); // R4
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !rld) |=> $stable(cnt_q)); // R5
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rld && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R2
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reboot_block_i(reboot_block_i), .reset_req_o(reset_req_o),
  .cnt_q(cnt_q), .init_q(init_q), .halt_q(halt_q), .tick(tick),
  .second_flag(flags.second)
);

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_rdata;
  logic        reboot_block_i = 1'b0;
  logic        reset_req_o;

  always #4 clk = ~clk;

  wdog_two_stage #(.TICK_DIV(DIV)) u_wdog_two_stage (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .reboot_block_i(reboot_block_i),
    .reset_req_o(reset_req_o)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    vectors = 0;
  int    errors = 0;
  logic  probe = 1'b0;
  int    req_high = 0;
  int    req_rises = 0;
  logic  req_prev = 1'b0;

  task automatic check(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (probe && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(int'(reg_rdata), int'(it.exp), it.tag);
    end
    if (rst_n) begin
      if (reset_req_o) req_high++;
      if (reset_req_o && !req_prev) req_rises++;
      req_prev = reset_req_o;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  bit timed_out = 0;

  initial begin
    fork
      begin
        edges(3);
        rst_n = 1'b1;
        // reset state
        rd(8'h00, 16'h0004, "R1 count");
        rd(8'h04, 16'h0000, "R1 sts1");
        rd(8'h06, 16'h0000, "R1 sts2");
        rd(8'h08, 16'h0800, "R1 halt");
        rd(8'h12, 16'h0004, "R1 init");
        check(req_high, 0, "R1 reset request low");
        // initial value programming
        wr(8'h12, 16'h0002); rd(8'h12, 16'h0004, "R3 below-floor ignored");
        wr(8'h12, 16'h0003); rd(8'h12, 16'h0004, "R3 value 3 ignored");
        wr(8'h12, 16'h0405); rd(8'h12, 16'h0005, "R3 10-bit field");
        wr(8'h12, 16'h03FF); rd(8'h12, 16'h03FF, "R3 max value");
        wr(8'h12, 16'h0006); rd(8'h12, 16'h0006, "R3 readback");
        // halted: frozen, reload still loads
        edges(40); rd(8'h00, 16'h0004, "R5 frozen while halted");
        wr(8'h00, 16'h0001); rd(8'h00, 16'h0006, "R4 reload while halted");
        wr(8'h08, 16'h0000); rd(8'h08, 16'h0000, "R5 halt readback");
        // run: reload at k=0
        wr(8'h00, 16'h0001);
        edges(10); rd(8'h00, 16'h0004, "R2 two ticks");
        edges(14); rd(8'h00, 16'h0000, "R2 reached zero");
        rd(8'h04, 16'h0000, "R2 no early expiry");
        edges(4);  rd(8'h04, 16'h0008, "R6 first timeout flag");
        rd(8'h00, 16'h0006, "R6 auto reload");
        check(req_high, 0, "R8 no reset on first expiry");
        wr(8'h04, 16'h0000); rd(8'h04, 16'h0008, "R7 write zero keeps flag");
        wr(8'h04, 16'h0008); rd(8'h04, 16'h0000, "R7 w1c clears");
        edges(26); rd(8'h04, 16'h0008, "R6 first again after service");
        rd(8'h06, 16'h0000, "R8 no second flag");
        check(req_high, 0, "R8 still no reset");
        edges(28); rd(8'h06, 16'h0002, "R9 second timeout flag");
        check(req_rises, 1, "R9 reset requested");
        check(req_high, 1, "R10 one-cycle pulse");
        edges(28); rd(8'h06, 16'h0006, "R11 boot flag set");
        rd(8'h04, 16'h0008, "R10 first flag latched");
        check(req_rises, 2, "R9 second pulse");
        check(req_high, 2, "R10 pulse widths");
        wr(8'h06, 16'h0006); rd(8'h06, 16'h0000, "R7 clear sts2");
        wr(8'h04, 16'h0008); rd(8'h04, 16'h0000, "R7 clear sts1");
        // no-reboot gate
        reboot_block_i = 1'b1;
        wr(8'h00, 16'h0001);
        edges(28); rd(8'h04, 16'h0008, "R12 first flag recorded");
        edges(28); rd(8'h06, 16'h0002, "R12 second flag recorded");
        check(req_rises, 2, "R12 reset suppressed");
        // halt mid-run
        wr(8'h08, 16'h0800); rd(8'h00, 16'h0006, "R5 count at halt");
        edges(20); rd(8'h00, 16'h0006, "R5 count frozen");
        rd(8'h08, 16'h0800, "R5 halt set readback");
        reboot_block_i = 1'b0;
      end
      begin
        edges(20000);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule